// File: doc/BRIEF.md
# Looping Scatter-Gather Playback Fetcher

This block feeds a playback stream from memory. Software builds a table of buffer segments in memory. Each entry holds a start address, a length in bytes and a flag asking for a completion pulse. Software then sets the run bit. The engine reads one table entry, fetches that segment one 32-bit word at a time and turns each word into aligned 32-bit samples. Each sample carries a channel tag and is pushed into a downstream FIFO. After the final entry it goes back to the first, so the stream loops for as long as run stays set.

Memory is reached through a plain request/response read port with at most one read in flight. A byte-offset position counter is kept in its own register, apart from the configuration inputs. Software can poll it to see how far playback has gone within the whole looping buffer.

Top module: `sgd_ring_dma`

## Requirements
- R1: While reset is high, and after it while run is low, there is no read request, no sample, no completion pulse, and the position reads 0.
- R2: Table entry i is read from list_base + 16*i as three single-word reads in this order: +0 segment address, +4 segment byte length, +8 flags (bit 0 = completion flag, other bits ignored). A request holds its address until it is accepted, and only one read is outstanding at a time.
- R3: Segment words are fetched in ascending address order from the segment start, 4 bytes per word. An entry with length 0 is skipped and produces no sample.
- R4: After the last entry (index list_len-1) is used up, the engine continues with entry 0 without any software action.
- R5: Word length code 0 (16-bit) gives two samples per word: bits 15:0 first, then bits 31:16, each output as {half,16'h0}. Code 1 (24-bit) gives {word[23:0],8'h0}. Codes 2 and 3 (32-bit) pass the word unchanged.
- R6: The channel tag counts 0..N-1 and then repeats, with N = 2*(chan_sel+1), so codes 0..3 give 2, 4, 6 and 8 channels. It starts at 0 each time the engine starts.
- R7: The position rises by 4 for each word that has been fully emitted. It becomes 0 instead when the last word of entry list_len-1 is emitted.
- R8: In the cycle after the last sample of an entry whose completion flag is set, done_pulse is high for exactly one cycle and done_idx gives that entry's index. At that same moment the position already includes the finished entry.
- R9: A data word is requested only when fifo_free is at least the number of samples per word. No sample is ever written when the FIFO is full, and none is lost.
- R10: Clearing run lets the word in flight finish. After that there are no new requests and no samples, and the position holds its value.
- R11: Setting run again from idle restarts at entry 0, with the position cleared to 0 and the channel tag at 0.
- R12: With list_len equal to 0, setting run causes no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_run | input | 1 | Run enable |
| cfg_list_base | input | 32 | Byte address of table entry 0 |
| cfg_list_len | input | IDX_W+1 | Number of table entries |
| cfg_chan_sel | input | 2 | Channel count code |
| cfg_wlen | input | 2 | Sample word length code |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_addr | output | 32 | Read byte address |
| rd_req_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| fifo_free | input | FREE_W | Free sample slots in the downstream FIFO |
| smp_valid | output | 1 | Sample written this cycle |
| smp_data | output | 32 | Left-aligned sample |
| smp_chan | output | 3 | Channel tag of the sample |
| pos_bytes | output | 32 | Byte position in the looping buffer |
| done_pulse | output | 1 | Entry-completion pulse |
| done_idx | output | IDX_W | Index of the completed entry |

## Verification
The last word of the final table entry does two things in one step when that entry has its completion flag set: it raises the completion pulse, and it wraps the position back to zero. The directed case and every random table end on such an entry. The bench checks, in the cycle after the final sample, that done_pulse and done_idx are correct and that pos_bytes is already 0 rather than the buffer total. A second overlap comes from holding the downstream FIFO undrained while a word is being fetched. The bench checks that its FIFO model never overflows and that the sample sequence continues without a gap once draining resumes.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 16;

    typedef enum logic [1:0] {
        WL_16  = 2'd0,
        WL_24  = 2'd1,
        WL_32  = 2'd2,
        WL_32X = 2'd3
    } wlen_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_DATA_REQ,
        ST_DATA_WAIT,
        ST_EMIT
    } eng_st_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] remain;
        logic        irq;
    } seg_t;

    function automatic logic [1:0] samples_per_word(input wlen_e wl);
        return (wl == WL_16) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [3:0] chan_total(input logic [1:0] sel);
        return {1'b0, sel, 1'b0} + 4'd2;
    endfunction

    function automatic logic [31:0] align_sample(input logic [31:0] w, input wlen_e wl,
                                                 input logic upper);
        case (wl)
            WL_16:   return upper ? {w[31:16], 16'h0000} : {w[15:0], 16'h0000};
            WL_24:   return {w[23:0], 8'h00};
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/sgd_pos.sv
module sgd_pos (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        step,
    input  logic        wrap,
    output logic [31:0] pos
);
    import sgd_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clear || wrap) begin
            pos <= '0;
        end else if (step) begin
            pos <= pos + 32'(WORD_BYTES);
        end
    end

    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (pos != $past(pos)) |-> ((pos == $past(pos) + 32'd4) || (pos == 32'd0))); // R7

endmodule

// File: rtl/sgd_unpack.sv
module sgd_unpack #(
    parameter int FREE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              load,
    input  logic [31:0]       word_in,
    input  sgd_pkg::wlen_e    wlen,
    input  logic [1:0]        chan_sel,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              smp_valid,
    output logic [31:0]       smp_data,
    output logic [2:0]        smp_chan,
    output logic              word_last
);
    import sgd_pkg::*;

    logic [31:0] word_q;
    logic [1:0]  left_q;
    logic        upper_q;
    logic [3:0]  nch;

    assign nch       = chan_total(chan_sel);
    assign smp_valid = (left_q != 2'd0);
    assign word_last = (left_q == 2'd1);
    assign smp_data  = align_sample(word_q, wlen, upper_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            left_q   <= '0;
            upper_q  <= 1'b0;
            smp_chan <= '0;
        end else begin
            if (start) begin
                smp_chan <= '0;
            end
            if (load) begin
                word_q  <= word_in;
                left_q  <= samples_per_word(wlen);
                upper_q <= 1'b0;
            end else if (left_q != 2'd0) begin
                left_q   <= left_q - 2'd1;
                upper_q  <= 1'b1;
                smp_chan <= (({1'b0, smp_chan} + 4'd1) == nch) ? 3'd0 : smp_chan + 3'd1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (fifo_free != '0)); // R9

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> ({1'b0, smp_chan} < nch)); // R6

endmodule

// File: rtl/sgd_ctrl.sv
module sgd_ctrl #(
    parameter int IDX_W  = 4,
    parameter int FREE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [31:0]       list_base,
    input  logic [IDX_W:0]    list_len,
    input  sgd_pkg::wlen_e    wlen,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              rd_req_valid,
    output logic [31:0]       rd_req_addr,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    input  logic [31:0]       rd_rsp_data,
    output logic              word_load,
    input  logic              word_last,
    output logic              start,
    output logic              pos_step,
    output logic              pos_wrap,
    output logic              done_pulse,
    output logic [IDX_W-1:0]  done_idx
);
    import sgd_pkg::*;

    localparam int LEN_W = IDX_W + 1;

    eng_st_e          st;
    logic [1:0]       fld;
    logic [IDX_W-1:0] idx;
    seg_t             seg;

    logic room, last_entry, seg_done, emit_end, skip_zero;

    assign room       = fifo_free >= FREE_W'(samples_per_word(wlen));
    assign last_entry = (LEN_W'(idx) + LEN_W'(1)) == list_len;
    assign seg_done   = seg.remain <= 32'(WORD_BYTES);
    assign emit_end   = (st == ST_EMIT) && word_last;
    assign skip_zero  = (st == ST_DESC_WAIT) && rd_rsp_valid && (fld == 2'd2) && run &&
                        (seg.remain == 32'd0);

    assign rd_req_valid = (st == ST_DESC_REQ) || ((st == ST_DATA_REQ) && room);
    assign rd_req_addr  = (st == ST_DESC_REQ)
                        ? list_base + (32'(idx) * 32'(DESC_BYTES)) + (32'(fld) * 32'(WORD_BYTES))
                        : seg.addr;

    assign start     = (st == ST_IDLE) && run && (list_len != '0);
    assign word_load = (st == ST_DATA_WAIT) && rd_rsp_valid;
    assign pos_wrap  = (emit_end && seg_done && last_entry) || (skip_zero && last_entry);
    assign pos_step  = emit_end && !(seg_done && last_entry);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            fld        <= '0;
            idx        <= '0;
            seg        <= '0;
            done_pulse <= 1'b0;
            done_idx   <= '0;
        end else begin
            done_pulse <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        idx <= '0;
                        fld <= '0;
                        st  <= ST_DESC_REQ;
                    end
                end
                ST_DESC_REQ: begin
                    if (rd_req_ready) st <= ST_DESC_WAIT;
                end
                ST_DESC_WAIT: begin
                    if (rd_rsp_valid) begin
                        case (fld)
                            2'd0:    seg.addr   <= rd_rsp_data;
                            2'd1:    seg.remain <= rd_rsp_data;
                            default: seg.irq    <= rd_rsp_data[0];
                        endcase
                        if (!run) begin
                            st <= ST_IDLE;
                        end else if (fld != 2'd2) begin
                            fld <= fld + 2'd1;
                            st  <= ST_DESC_REQ;
                        end else if (seg.remain == 32'd0) begin
                            fld <= '0;
                            idx <= last_entry ? '0 : idx + IDX_W'(1);
                            st  <= ST_DESC_REQ;
                        end else begin
                            st <= ST_DATA_REQ;
                        end
                    end
                end
                ST_DATA_REQ: begin
                    if (room && rd_req_ready) st <= ST_DATA_WAIT;
                    else if (!room && !run)   st <= ST_IDLE;
                end
                ST_DATA_WAIT: begin
                    if (rd_rsp_valid) st <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (word_last) begin
                        seg.addr   <= seg.addr + 32'(WORD_BYTES);
                        seg.remain <= seg.remain - 32'(WORD_BYTES);
                        if (seg_done) begin
                            if (seg.irq) begin
                                done_pulse <= 1'b1;
                                done_idx   <= idx;
                            end
                            fld <= '0;
                            idx <= last_entry ? '0 : idx + IDX_W'(1);
                            st  <= run ? ST_DESC_REQ : ST_IDLE;
                        end else begin
                            st <= run ? ST_DATA_REQ : ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_IDLE) && (list_len == '0)) |=> !rd_req_valid); // R12

endmodule

// File: rtl/sgd_ring_dma.sv
module sgd_ring_dma #(
    parameter int IDX_W  = 4,
    parameter int FREE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_run,
    input  logic [31:0]       cfg_list_base,
    input  logic [IDX_W:0]    cfg_list_len,
    input  logic [1:0]        cfg_chan_sel,
    input  logic [1:0]        cfg_wlen,
    output logic              rd_req_valid,
    output logic [31:0]       rd_req_addr,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    input  logic [31:0]       rd_rsp_data,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              smp_valid,
    output logic [31:0]       smp_data,
    output logic [2:0]        smp_chan,
    output logic [31:0]       pos_bytes,
    output logic              done_pulse,
    output logic [IDX_W-1:0]  done_idx
);
    import sgd_pkg::*;

    wlen_e wl;
    logic  word_load, word_last, start, pos_step, pos_wrap;

    assign wl = wlen_e'(cfg_wlen);

    sgd_ctrl #(.IDX_W(IDX_W), .FREE_W(FREE_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .run         (cfg_run),
        .list_base   (cfg_list_base),
        .list_len    (cfg_list_len),
        .wlen        (wl),
        .fifo_free   (fifo_free),
        .rd_req_valid(rd_req_valid),
        .rd_req_addr (rd_req_addr),
        .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data (rd_rsp_data),
        .word_load   (word_load),
        .word_last   (word_last),
        .start       (start),
        .pos_step    (pos_step),
        .pos_wrap    (pos_wrap),
        .done_pulse  (done_pulse),
        .done_idx    (done_idx)
    );

    sgd_unpack #(.FREE_W(FREE_W)) u_unpack (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load     (word_load),
        .word_in  (rd_rsp_data),
        .wlen     (wl),
        .chan_sel (cfg_chan_sel),
        .fifo_free(fifo_free),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .smp_chan (smp_chan),
        .word_last(word_last)
    );

    sgd_pos u_pos (
        .clk  (clk),
        .rst  (rst),
        .clear(start),
        .step (pos_step),
        .wrap (pos_wrap),
        .pos  (pos_bytes)
    );

    AST_WRAP_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && (({1'b0, done_idx} + (IDX_W+1)'(1)) == cfg_list_len))
        |-> (pos_bytes == 32'd0)); // R7

endmodule

// File: tb/sgd_ring_dma_bench.sv
`timescale 1ns/1ps
module sgd_ring_dma_bench;

    localparam int IDX_W     = 4;
    localparam int FREE_W    = 4;
    localparam int DEPTH     = 6;
    localparam int MEM_WORDS = 1024;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_run = 1'b0;
    logic [31:0]       cfg_list_base = '0;
    logic [IDX_W:0]    cfg_list_len = '0;
    logic [1:0]        cfg_chan_sel = '0;
    logic [1:0]        cfg_wlen = 2'd2;
    logic              rd_req_valid;
    logic [31:0]       rd_req_addr;
    logic              rd_req_ready = 1'b0;
    logic              rd_rsp_valid = 1'b0;
    logic [31:0]       rd_rsp_data = '0;
    logic [FREE_W-1:0] fifo_free = FREE_W'(DEPTH);
    logic              smp_valid;
    logic [31:0]       smp_data;
    logic [2:0]        smp_chan;
    logic [31:0]       pos_bytes;
    logic              done_pulse;
    logic [IDX_W-1:0]  done_idx;

    sgd_ring_dma #(.IDX_W(IDX_W), .FREE_W(FREE_W)) u_sgd_ring_dma (
        .clk(clk), .rst(rst), .cfg_run(cfg_run), .cfg_list_base(cfg_list_base),
        .cfg_list_len(cfg_list_len), .cfg_chan_sel(cfg_chan_sel), .cfg_wlen(cfg_wlen),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .fifo_free(fifo_free),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
        .pos_bytes(pos_bytes), .done_pulse(done_pulse), .done_idx(done_idx)
    );

    initial forever #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] d_addr [8];
    int          d_len [8];
    bit          d_ioc [8];
    int          nd;

    int g_d, g_off, g_chan, loops, g_wl, g_nch;
    bit g_hi, gen_active, drain_en;
    bit exp_done_next;
    int exp_done_idx;
    logic [31:0] exp_done_pos;
    string data_tag = "R3";

    bit          pend;
    logic [31:0] pend_addr;
    int          lat;
    int          fifo_cnt;
    logic [31:0] req_log [4];
    int          req_n;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sample(input logic [31:0] w, input int wl, input bit hi);
        if (wl == 0) return hi ? {w[31:16], 16'h0} : {w[15:0], 16'h0};
        if (wl == 1) return {w[23:0], 8'h0};
        return w;
    endfunction

    task automatic gen_reset();
        g_d = 0; g_off = 0; g_hi = 0; g_chan = 0; loops = 0;
        exp_done_next = 0;
        g_wl  = int'(cfg_wlen);
        g_nch = 2 * (int'(cfg_chan_sel) + 1);
    endtask

    task automatic build(input int n, input logic [31:0] base, input int zero_at,
                         input bit directed);
        int ptr;
        ptr = 256;
        nd  = n;
        for (int i = 0; i < n; i++) begin
            int words;
            if (directed) begin
                words = (i == 0) ? 2 : (i == 1) ? 1 : 3;
                d_ioc[i] = (i != 0);
            end else begin
                words = 1 + int'($urandom % 8);
                d_ioc[i] = (i == n - 1) ? 1'b1 : 1'($urandom % 2);
            end
            if (i == zero_at) words = 0;
            d_addr[i] = 32'(ptr * 4);
            d_len[i]  = words * 4;
            for (int k = 0; k < words; k++) mem[ptr + k] = $urandom;
            ptr += words + int'($urandom % 4);
            mem[(base >> 2) + 32'(4 * i)]     = d_addr[i];
            mem[(base >> 2) + 32'(4 * i + 1)] = 32'(d_len[i]);
            mem[(base >> 2) + 32'(4 * i + 2)] = {$urandom % 32'h7fff_ffff, 1'b0} | 32'(d_ioc[i]);
        end
    endtask

    task automatic take_sample();
        int          widx;
        logic [31:0] ex;
        int          cum;
        widx = int'(((d_addr[g_d] + 32'(g_off)) >> 2) % MEM_WORDS);
        ex   = exp_sample(mem[widx], g_wl, g_hi);
        check(smp_data == ex, data_tag, smp_data, ex);
        check(int'(smp_chan) == g_chan, "R6 channel tag", 32'(smp_chan), 32'(g_chan));
        g_chan = (g_chan + 1) % g_nch;
        if (g_wl == 0 && !g_hi) begin
            g_hi = 1;
        end else begin
            g_hi = 0;
            g_off += 4;
            if (g_off >= d_len[g_d]) begin
                cum = 0;
                for (int k = 0; k <= g_d; k++) cum += d_len[k];
                if (d_ioc[g_d]) begin
                    exp_done_next = 1;
                    exp_done_idx  = g_d;
                    exp_done_pos  = (g_d == nd - 1) ? 32'd0 : 32'(cum);
                end
                g_off = 0;
                do begin
                    if (g_d == nd - 1) begin g_d = 0; loops++; end
                    else g_d++;
                end while (d_len[g_d] == 0);
            end
        end
    endtask

    // memory responder, FIFO model and output monitor
    initial begin
        pend = 0; lat = 0; fifo_cnt = 0; req_n = 0; drain_en = 1; gen_active = 1;
        forever begin
            bit done_due;
            @(negedge clk);
            if (pend && lat == 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem[pend_addr[11:2]];
                pend = 0;
            end else begin
                rd_rsp_valid = 1'b0;
                if (pend) lat--;
            end
            rd_req_ready = ($urandom % 4) != 0;
            if (fifo_cnt > 0 && drain_en && ($urandom % 3) != 0) fifo_cnt--;
            fifo_free = FREE_W'(DEPTH - fifo_cnt);
            #1;
            if (!rst) begin
                if (rd_req_valid && rd_req_ready) begin
                    check(!pend, "R2 single outstanding read", 32'(pend), 32'd0);
                    pend = 1; pend_addr = rd_req_addr; lat = int'($urandom % 3);
                    if (req_n < 4) req_log[req_n] = rd_req_addr;
                    req_n++;
                end
                done_due = exp_done_next;
                exp_done_next = 0;
                if (done_due) begin
                    check(done_pulse, "R8 completion pulse", 32'(done_pulse), 32'd1);
                    check(int'(done_idx) == exp_done_idx, "R8 completion index",
                          32'(done_idx), 32'(exp_done_idx));
                    check(pos_bytes == exp_done_pos, "R7 position at completion",
                          pos_bytes, exp_done_pos);
                end else if (done_pulse) begin
                    check(0, "R8 spurious pulse", 32'd1, 32'd0);
                end
                if (smp_valid) begin
                    check(fifo_cnt < DEPTH, "R9 FIFO overflow", 32'(fifo_cnt), 32'(DEPTH - 1));
                    fifo_cnt++;
                    if (gen_active) take_sample();
                    else check(0, "R12 sample while list empty", smp_data, 32'd0);
                end
            end else begin
                pend = 0;
            end
        end
    end

    task automatic idle_reset();
        cfg_run = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_loops(input logic [31:0] base, input int n, input int want);
        cfg_list_base = base;
        cfg_list_len  = (IDX_W+1)'(n);
        gen_reset();
        req_n = 0;
        cfg_run = 1'b1;
        for (int c = 0; c < 20000 && loops < want; c++) @(negedge clk);
        check(loops >= want, "R4 looped over the table", 32'(loops), 32'(want));
        check(req_log[0] == base,          "R2 address word fetch", req_log[0], base);
        check(req_log[1] == base + 32'd4,  "R2 length word fetch",  req_log[1], base + 32'd4);
        check(req_log[2] == base + 32'd8,  "R2 flags word fetch",   req_log[2], base + 32'd8);
        check(req_log[3] == d_addr[0],     "R3 first data word",    req_log[3], d_addr[0]);
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        check(!rd_req_valid, "R1 no request in reset", 32'(rd_req_valid), 32'd0);
        check(!smp_valid, "R1 no sample in reset", 32'(smp_valid), 32'd0);
        check(pos_bytes == 0, "R1 position in reset", pos_bytes, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        #2;
        check(!rd_req_valid && !done_pulse, "R1 idle with run low", 32'(rd_req_valid), 32'd0);
        check(pos_bytes == 0, "R1 position idle", pos_bytes, 32'd0);

        // directed: completion on the last entry coincides with the position wrap
        @(negedge clk);
        cfg_wlen = 2'd2; cfg_chan_sel = 2'd0; data_tag = "R3 32-bit data";
        build(3, 32'h0, -1, 1'b1);
        run_loops(32'h0, 3, 3);
        idle_reset();

        // 16-bit, six channels, zero-length entry in the middle
        cfg_wlen = 2'd0; cfg_chan_sel = 2'd2; data_tag = "R5 16-bit split";
        build(5, 32'h40, 2, 1'b0);
        run_loops(32'h40, 5, 2);
        idle_reset();

        // 24-bit, eight channels, downstream stall
        cfg_wlen = 2'd1; cfg_chan_sel = 2'd3; data_tag = "R5 24-bit align";
        build(4, 32'h80, -1, 1'b0);
        run_loops(32'h80, 4, 1);
        drain_en = 0;
        repeat (60) @(negedge clk);
        #2;
        check(fifo_cnt == DEPTH, "R9 FIFO filled during stall", 32'(fifo_cnt), 32'(DEPTH));
        drain_en = 1;
        for (int c = 0; c < 20000 && loops < 3; c++) @(negedge clk);
        check(loops >= 3, "R9 stream resumed after stall", 32'(loops), 32'd3);

        // stop mid-stream, then restart from entry 0
        cfg_run = 1'b0;
        repeat (20) @(negedge clk);
        #2;
        held = pos_bytes;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            #2;
            if (rd_req_valid || smp_valid || pos_bytes != held) begin
                check(0, "R10 activity after stop", pos_bytes, held);
            end
        end
        check(pos_bytes == held, "R10 position held after stop", pos_bytes, held);
        @(negedge clk);
        gen_reset();
        req_n = 0;
        cfg_run = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        check(pos_bytes == 0, "R11 position cleared on restart", pos_bytes, 32'd0);
        for (int c = 0; c < 20000 && loops < 1; c++) @(negedge clk);
        check(req_log[0] == 32'h80, "R11 restart at entry 0", req_log[0], 32'h80);
        check(loops >= 1, "R11 stream after restart", 32'(loops), 32'd1);
        idle_reset();

        // empty table
        gen_active = 0;
        cfg_list_len = '0;
        cfg_run = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            #2;
            if (rd_req_valid) check(0, "R12 request with empty table", 32'd1, 32'd0);
        end
        check(!rd_req_valid && !smp_valid, "R12 idle with empty table", 32'(rd_req_valid), 32'd0);
        cfg_run = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule